// File: doc/BRIEF.md
# Two-Channel Compare Match Timer

This block is a small peripheral timer with two independent channels. Each channel owns a 16-bit up-counter and a 16-bit compare constant. A channel counts only while its bit in the shared start register is set, and it steps on a count enable drawn from one free-running prescaler. Each channel chooses a divide ratio of 8, 32, 128 or 512 of the peripheral clock. When the counter equals the constant on a count step, the counter wraps to zero and the channel records a match. The match then produces either an interrupt request or a DMA transfer request, chosen per channel.

Software reaches every register through a plain single-cycle read/write port, and read data is combinational from the address. A module-level clock enable stands in for the clock-gating cell. While it is low, the whole block is frozen.

Top module: `cmt_timer`

## Requirements
- R1: After reset the start register, both control registers and both counters read 0, both compare constants read 0xFFFF, and irq_o and dreq_o are 0.
- R2: Address map: 0 is the start register, with bit c starting channel c. For the other registers, addr[2] selects the channel and addr[1:0] selects the register: 1 is control, 2 is the constant, 3 is the counter. Control layout is clock select in [1:0], interrupt enable in [6], match flag in [7] and DMA select in [8]. Unused bits read 0, and writing 1 to bit 7 never sets the flag.
- R3: The clock select codes 0, 1, 2 and 3 give one count step every 8, 32, 128 and 512 enabled clock cycles. Matches recur every (constant + 1) × divisor cycles.
- R4: On a count step where the counter equals the constant, the counter becomes 0 and the match flag becomes 1 at the same clock edge.
- R5: A channel whose start bit is 0 holds its counter value.
- R6: A counter write at the same edge as a count step loads the written value, and the increment is lost.
- R7: With DMA select 0, writing 0 to bit 7 clears the flag only after a control read has returned the flag as 1. Without that read, the flag stays set.
- R8: irq_o[c] equals the channel's flag AND its interrupt enable, and it is 0 when DMA select is 1.
- R9: With DMA select 1, every match gives a dreq_o[c] pulse exactly one cycle wide, one cycle after the match edge. A one-cycle dack_i[c] clears the flag.
- R10: While clk_en_i is 0, nothing advances: counters, flags, prescaler and all registers hold, writes are ignored, and no request is issued. Counting resumes when clk_en_i returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Module clock enable (models clock stop) |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe (arms the flag clear) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational from addr_i |
| dack_i | input | 2 | Per-channel DMA acknowledge |
| irq_o | output | 2 | Per-channel interrupt request (level) |
| dreq_o | output | 2 | Per-channel DMA request (one-cycle pulse) |

## Verification
A software write to a counter can land on the same edge as a prescaler step that would increment it. The bench provokes this by watching the counter change, which fixes the phase of the divide-by-8 step. It then issues the write exactly eight cycles later. The collision is judged correct when the write value is read back unchanged, the value is still there one cycle before the next step, and it has risen by exactly one after that step.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int CKS_W    = 2;               // clock select field width
  localparam int N_DIV    = 1 << CKS_W;      // number of prescaler taps
  localparam int DIV_BASE = 3;               // log2 of smallest divisor
  localparam int DIV_STEP = 2;               // log2 ratio between taps
  localparam int B_IE     = 6;
  localparam int B_FLAG   = 7;
  localparam int B_DMA    = 8;

  typedef enum logic [1:0] {
    OFS_GLOBAL = 2'd0,
    OFS_CTRL   = 2'd1,
    OFS_CONST  = 2'd2,
    OFS_COUNT  = 2'd3
  } reg_ofs_e;

  typedef struct packed {
    logic             dma;
    logic             ie;
    logic [CKS_W-1:0] cks;
  } ctrl_t;
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
#(
  parameter int N_TAP = N_DIV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [N_TAP-1:0] tick_o
);
  localparam int DIV_W = DIV_BASE + DIV_STEP * (N_TAP - 1);

  logic [DIV_W-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   div_q <= '0;
    else if (en_i) div_q <= div_q + 1'b1;
  end

  for (genvar k = 0; k < N_TAP; k++) begin : g_tap
    localparam int TW = DIV_BASE + DIV_STEP * k;
    assign tick_o[k] = en_i & (&div_q[TW-1:0]);
    if (k > 0) begin : g_nest
      // a slower tap only fires together with every faster one
      p_tap_nest_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o[k] |-> tick_o[k-1]);
    end
  end

  p_tap_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o[0] |=> !tick_o[0]);
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [N_DIV-1:0] tick_i,
  input  logic             start_i,
  input  logic             ctrl_we_i,
  input  logic             ctrl_re_i,
  input  logic             const_we_i,
  input  logic             cnt_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             dack_i,
  output ctrl_t            ctrl_o,
  output logic             flag_o,
  output logic [CNT_W-1:0] const_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             irq_o,
  output logic             dreq_o
);
  ctrl_t            ctrl_q;
  logic             flag_q, flag_d, armed_q, dreq_q;
  logic [CNT_W-1:0] cnt_q, const_q;
  logic             step, match, sw_clr, hw_clr;

  assign step   = en_i & start_i & tick_i[ctrl_q.cks];
  assign match  = step & (cnt_q == const_q);
  // software clear needs a prior read of the flag as 1
  assign sw_clr = ctrl_we_i & ~wdata_i[B_FLAG] & armed_q & ~ctrl_q.dma;
  assign hw_clr = dack_i & ctrl_q.dma;

  always_comb begin
    flag_d = flag_q;
    if (en_i) begin
      if (match)                flag_d = 1'b1;
      else if (sw_clr | hw_clr) flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      dreq_q  <= 1'b0;
      cnt_q   <= '0;
      const_q <= '1;
    end else begin
      flag_q <= flag_d;
      dreq_q <= match & ctrl_q.dma;
      if (en_i) begin
        armed_q <= ~match & flag_d & (armed_q | (ctrl_re_i & flag_q));
        if (ctrl_we_i) begin
          ctrl_q.cks <= wdata_i[CKS_W-1:0];
          ctrl_q.ie  <= wdata_i[B_IE];
          ctrl_q.dma <= wdata_i[B_DMA];
        end
        if (const_we_i) const_q <= wdata_i;
        if (cnt_we_i)   cnt_q <= wdata_i;
        else if (match) cnt_q <= '0;
        else if (step)  cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign ctrl_o  = ctrl_q;
  assign flag_o  = flag_q;
  assign const_o = const_q;
  assign cnt_o   = cnt_q;
  assign irq_o   = flag_q & ctrl_q.ie & ~ctrl_q.dma;
  assign dreq_o  = dreq_q;

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match && !cnt_we_i |=> (cnt_q == '0) && flag_q);

  p_cnt_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !start_i && !cnt_we_i |=> $stable(cnt_q));

  p_write_wins_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && cnt_we_i |=> cnt_q == $past(wdata_i));

  p_dreq_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dreq_q |=> !dreq_q);

  p_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q) && $stable(flag_q) && !dreq_q);
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter  int N_CH  = 2,
  parameter  int CNT_W = 16,
  localparam int CH_AW = (N_CH > 1) ? $clog2(N_CH) : 1,
  localparam int AW    = CH_AW + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic             we_i,
  input  logic             re_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] rdata_o,
  input  logic [N_CH-1:0]  dack_i,
  output logic [N_CH-1:0]  irq_o,
  output logic [N_CH-1:0]  dreq_o
);
  logic [N_DIV-1:0] tick;
  logic [N_CH-1:0]  start_q;
  logic [CH_AW-1:0] ch_sel;
  reg_ofs_e         ofs;
  logic             start_hit;

  ctrl_t            ctrl_a  [N_CH];
  logic [CNT_W-1:0] const_a [N_CH];
  logic [CNT_W-1:0] cnt_a   [N_CH];
  logic [N_CH-1:0]  flag_a;

  assign ch_sel    = addr_i[AW-1:2];
  assign ofs       = reg_ofs_e'(addr_i[1:0]);
  assign start_hit = (addr_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                            start_q <= '0;
    else if (clk_en_i && we_i && start_hit) start_q <= wdata_i[N_CH-1:0];
  end

  cmt_prescaler #(.N_TAP(N_DIV)) u_presc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (clk_en_i),
    .tick_o (tick)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hit;
    assign hit = (int'(ch_sel) == c);

    cmt_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (clk_en_i),
      .tick_i     (tick),
      .start_i    (start_q[c]),
      .ctrl_we_i  (we_i & hit & (ofs == OFS_CTRL)),
      .ctrl_re_i  (re_i & hit & (ofs == OFS_CTRL)),
      .const_we_i (we_i & hit & (ofs == OFS_CONST)),
      .cnt_we_i   (we_i & hit & (ofs == OFS_COUNT)),
      .wdata_i    (wdata_i),
      .dack_i     (dack_i[c]),
      .ctrl_o     (ctrl_a[c]),
      .flag_o     (flag_a[c]),
      .const_o    (const_a[c]),
      .cnt_o      (cnt_a[c]),
      .irq_o      (irq_o[c]),
      .dreq_o     (dreq_o[c])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (int'(ch_sel) < N_CH) begin
      case (ofs)
        OFS_GLOBAL: if (start_hit) rdata_o[N_CH-1:0] = start_q;
        OFS_CTRL: begin
          rdata_o[CKS_W-1:0] = ctrl_a[ch_sel].cks;
          rdata_o[B_IE]      = ctrl_a[ch_sel].ie;
          rdata_o[B_FLAG]    = flag_a[ch_sel];
          rdata_o[B_DMA]     = ctrl_a[ch_sel].dma;
        end
        OFS_CONST: rdata_o = const_a[ch_sel];
        OFS_COUNT: rdata_o = cnt_a[ch_sel];
        default:   rdata_o = '0;
      endcase
    end
  end

  p_start_freeze_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> $stable(start_q));
endmodule

// File: tb/cmt_timer_tb.sv
`timescale 1ns/1ps
module cmt_timer_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clk_en_i = 1'b1;
  logic        we_i = 1'b0;
  logic        re_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [1:0]  dack_i = '0;
  logic [1:0]  irq_o, dreq_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #2.5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  cmt_timer u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_i(clk_en_i),
    .we_i(we_i), .re_i(re_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .rdata_o(rdata_o), .dack_i(dack_i), .irq_o(irq_o), .dreq_o(dreq_o)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  addr;
    logic [15:0] data;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 3'd0, 16'h0000, 16'h0000},
    '{1'b0, 3'd1, 16'h0000, 16'h0000},
    '{1'b0, 3'd2, 16'h0000, 16'hFFFF},
    '{1'b0, 3'd3, 16'h0000, 16'h0000},
    '{1'b0, 3'd5, 16'h0000, 16'h0000},
    '{1'b0, 3'd6, 16'h0000, 16'hFFFF},
    '{1'b0, 3'd7, 16'h0000, 16'h0000},
    '{1'b1, 3'd1, 16'h01FF, 16'h0000},
    '{1'b0, 3'd1, 16'h0000, 16'h0143},
    '{1'b1, 3'd6, 16'h1234, 16'h0000},
    '{1'b0, 3'd6, 16'h0000, 16'h1234},
    '{1'b1, 3'd7, 16'hABCD, 16'h0000},
    '{1'b0, 3'd7, 16'h0000, 16'hABCD},
    '{1'b1, 3'd1, 16'h0000, 16'h0000},
    '{1'b0, 3'd1, 16'h0000, 16'h0000},
    '{1'b0, 3'd2, 16'h0000, 16'hFFFF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    re_i = 1'b1; addr_i = a;
    #1 v = rdata_o;
    @(negedge clk_i);
    re_i = 1'b0;
  endtask

  // sel 0: irq_o[0], sel 1: dreq_o[1]
  task automatic wait_for(input int sel, input int limit, output int t, output bit ok);
    ok = 1'b0; t = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk_i);
      if ((sel == 0 && irq_o[0]) || (sel == 1 && dreq_o[1])) begin
        ok = 1'b1; t = cyc; break;
      end
    end
  endtask

  task automatic run_all();
    logic [15:0] v, v0, v1;
    int t1, t2;
    bit ok, seen;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 irq after reset", irq_o, 2'b00);
    chk("R1 dreq after reset", dreq_o, 2'b00);

    // table walk: reset values (R1) and register layout (R2)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) wr(VEC[i].addr, VEC[i].data);
      else begin
        rd(VEC[i].addr, v);
        chk($sformatf("R1 R2 table idx %0d", i), v, VEC[i].exp);
      end
    end

    // R6 collision of counter write and count step, R3 /8 spacing
    wr(3'd1, 16'h0000);
    wr(3'd3, 16'h0000);
    wr(3'd0, 16'h0001);
    rd(3'd3, v0);
    for (int i = 0; i < 20; i++) begin
      rd(3'd3, v);
      if (v != v0) break;
    end
    chk("R3 counter moves at /8", (v != v0), 1'b1);
    repeat (6) @(negedge clk_i);
    wr(3'd3, 16'h0100);
    rd(3'd3, v);
    chk("R6 write beats step", v, 16'h0100);
    repeat (6) @(negedge clk_i);
    rd(3'd3, v);
    chk("R3 no step before 8 cycles", v, 16'h0100);
    rd(3'd3, v);
    chk("R3 step after 8 cycles", v, 16'h0101);

    // R5 start bit cleared holds the counter
    wr(3'd0, 16'h0000);
    rd(3'd3, v0);
    repeat (40) @(negedge clk_i);
    rd(3'd3, v);
    chk("R5 counter held while stopped", v, v0);

    // R4 R7 R8 R3: constant 3, /8, interrupt mode
    wr(3'd2, 16'd3);
    wr(3'd3, 16'd0);
    wr(3'd1, 16'h0040);
    wr(3'd0, 16'h0001);
    addr_i = 3'd3;
    wait_for(0, 200, t1, ok);
    chk("R4 first match seen", ok, 1'b1);
    chk("R4 counter zero at match", rdata_o, 16'h0000);
    wr(3'd1, 16'h0040);
    rd(3'd1, v);
    chk("R7 clear without read ignored", v, 16'h00C0);
    wr(3'd1, 16'h0040);
    rd(3'd1, v);
    chk("R7 clear after read", v, 16'h0040);
    chk("R8 irq low after clear", irq_o[0], 1'b0);
    wait_for(0, 200, t2, ok);
    chk("R3 period (3+1)*8", t2 - t1, 32);
    wr(3'd1, 16'h0000);
    chk("R8 irq masked by enable", irq_o[0], 1'b0);
    rd(3'd1, v);
    chk("R8 flag kept while masked", v, 16'h0080);
    wr(3'd1, 16'h00C0);
    chk("R8 irq follows enable", irq_o[0], 1'b1);
    wr(3'd0, 16'h0000);

    // R3 /512 with constant 0
    wr(3'd2, 16'd0);
    wr(3'd3, 16'd0);
    wr(3'd1, 16'h0043);
    wr(3'd0, 16'h0001);
    wait_for(0, 2000, t1, ok);
    chk("R3 /512 first match", ok, 1'b1);
    rd(3'd1, v);
    wr(3'd1, 16'h0043);
    wait_for(0, 2000, t2, ok);
    chk("R3 period 1*512", t2 - t1, 512);
    wr(3'd0, 16'h0000);

    // R9 DMA mode on channel 1: constant 1, /32
    wr(3'd6, 16'd1);
    wr(3'd7, 16'd0);
    wr(3'd5, 16'h0141);
    wr(3'd0, 16'h0002);
    wait_for(1, 400, t1, ok);
    chk("R9 dma request seen", ok, 1'b1);
    chk("R9 irq held low in dma mode", irq_o[1], 1'b0);
    @(negedge clk_i);
    chk("R9 request one cycle wide", dreq_o[1], 1'b0);
    wait_for(1, 400, t2, ok);
    chk("R9 R3 request period 2*32", t2 - t1, 64);
    rd(3'd5, v);
    chk("R9 flag set in dma mode", v, 16'h01C1);
    dack_i = 2'b10;
    @(negedge clk_i);
    dack_i = 2'b00;
    rd(3'd5, v);
    chk("R9 acknowledge clears flag", v, 16'h0141);

    // R10 clock stop
    clk_en_i = 1'b0;
    rd(3'd7, v0);
    wr(3'd6, 16'h0055);
    seen = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (dreq_o[1]) seen = 1'b1;
    end
    chk("R10 no request while stopped", seen, 1'b0);
    rd(3'd7, v1);
    chk("R10 counter frozen", v1, v0);
    rd(3'd6, v);
    chk("R10 write ignored", v, 16'h0001);
    clk_en_i = 1'b1;
    wait_for(1, 200, t1, ok);
    chk("R10 counting resumes", ok, 1'b1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk_i);
        total++;
        bad++;
        $display("FAIL watchdog R1..all act=hung exp=done");
      end
    join_any
    disable fork;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule